// File: doc/BRIEF.md
# Open-Row-First Bank Request Scheduler

This block holds memory requests in a small on-chip buffer and decides, one bank at a time, which buffered request goes next to each bank controller. A request presents only its address. The block splits the address into byte, channel, bank and row fields. The bank field chooses the bank queue, and the row field is compared with the row that bank currently holds open.

For every bank, the scheduler first looks at requests that target the open row and issues the oldest of them. If no buffered request targets the open row, it issues the oldest request for that bank. Banks are arbitrated independently, so every bank with pending work can issue in the same cycle. A request stays in the buffer until its bank's issue handshake completes. The request input applies backpressure when the buffer is full, except in a cycle where an issue frees an entry.

Top module: `frfcfs_sched`

## Requirements
- R1: After reset the buffer is empty: every `issueValid` bit is 0 and `reqReady` is 1.
- R2: An address is decoded as byte = bits 12..0, channel = bits 16..13, bank = bits 20..17, row = bits 31..21. Only the bank field picks the issue port, so the channel bits never change routing.
- R3: When a bank holds a buffered request whose row equals that bank's `openRow` while `openRowValid` is 1, the bank issues such a request ahead of older requests to other rows.
- R4: When no buffered request for a bank hits its open row, the bank issues its oldest buffered request.
- R5: Among several requests that hit the open row of a bank, the oldest one is issued first.
- R6: Each bank is arbitrated on its own. Every bank with at least one buffered request asserts `issueValid` in the same cycle.
- R7: `reqReady` is 0 when all DEPTH entries are occupied and no issue handshake completes in that cycle. When a handshake completes, `reqReady` is 1 and the freed entry can take the new request.
- R8: A request leaves the buffer only when `issueValid` and `issueReady` of its bank are both 1 at a clock edge. A stalled bank keeps `issueValid` high and, with unchanged open-row inputs and no new request for that bank, keeps `issueAddr` stable.
- R9: A bank with no buffered request drives `issueValid` low.
- R10: While `openRowValid` of a bank is 0, no request counts as a hit and that bank issues its oldest request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Buffer can accept a request this cycle |
| reqAddr | input | ADDR_W (32) | Request address |
| issueValid | output | NBANK (16) | Per-bank issue strobe |
| issueReady | input | NBANK (16) | Per-bank controller accepts the issue |
| issueAddr | output | NBANK x ADDR_W | Address issued to each bank |
| openRowValid | input | NBANK (16) | Bank has a row open |
| openRow | input | NBANK x ROW_W (11) | Row currently open in each bank |

## Verification
A corrupted valid bit or a lost entry shows up as an issue port that stays high with nothing queued, or that stays low while work is pending. It also shows as `reqReady` disagreeing with the occupancy implied by accepted and issued handshakes. Either symptom appears in the same cycle as the bad state. A wrong age relation or hit comparison does not change the valid strobes. It appears on `issueAddr` in the first cycle where two candidates for one bank compete, so the bench keeps several requests per bank queued under changing open rows and compares every port in every cycle.

// File: rtl/frfcfs_pkg.sv
`timescale 1ns/1ps
package frfcfs_pkg;
  // Address layout: byte offset, then channel, then bank, then row.
  localparam int BYTE_W   = 13;
  localparam int CHAN_W   = 4;
  localparam int BANK_LSB = BYTE_W + CHAN_W;
endpackage

// File: rtl/frfcfs_datapath.sv
`timescale 1ns/1ps
module frfcfs_datapath #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [1+IDX_W+DEPTH-1:0]      strobes,
  input  logic [ADDR_W-1:0]             reqAddr,
  output logic [DEPTH-1:0]              entryValid,
  output logic [DEPTH-1:0][ADDR_W-1:0]  entryAddr,
  output logic [DEPTH-1:0][DEPTH-1:0]   olderThan
);
  typedef struct packed {
    logic             allocEn;
    logic [IDX_W-1:0] allocIdx;
    logic [DEPTH-1:0] freeMask;
  } strobes_t;

  strobes_t stb;
  assign stb = strobes;

  // olderThan[i][j] = 1 : entry j arrived before entry i
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entryValid <= '0;
      entryAddr  <= '0;
      olderThan  <= '0;
    end else begin
      entryValid <= entryValid & ~stb.freeMask;
      if (stb.allocEn) begin
        entryValid[stb.allocIdx] <= 1'b1;
        entryAddr[stb.allocIdx]  <= reqAddr;
        for (int i = 0; i < DEPTH; i++) begin
          if (IDX_W'(i) == stb.allocIdx)
            olderThan[i] <= entryValid & ~stb.freeMask;
          else
            olderThan[i][stb.allocIdx] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/frfcfs_ctrl.sv
`timescale 1ns/1ps
module frfcfs_ctrl
  import frfcfs_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int NBANK  = 16,
  parameter int ADDR_W = 32,
  localparam int IDX_W   = $clog2(DEPTH),
  localparam int BANK_W  = $clog2(NBANK),
  localparam int ROW_LSB = BANK_LSB + BANK_W,
  localparam int ROW_W   = ADDR_W - ROW_LSB
) (
  input  logic                          reqValid,
  output logic                          reqReady,
  input  logic [NBANK-1:0]              issueReady,
  output logic [NBANK-1:0]              issueValid,
  output logic [NBANK-1:0][ADDR_W-1:0]  issueAddr,
  input  logic [NBANK-1:0]              openRowValid,
  input  logic [NBANK-1:0][ROW_W-1:0]   openRow,
  input  logic [DEPTH-1:0]              entryValid,
  input  logic [DEPTH-1:0][ADDR_W-1:0]  entryAddr,
  input  logic [DEPTH-1:0][DEPTH-1:0]   olderThan,
  output logic [1+IDX_W+DEPTH-1:0]      strobes
);
  typedef struct packed {
    logic             allocEn;
    logic [IDX_W-1:0] allocIdx;
    logic [DEPTH-1:0] freeMask;
  } strobes_t;

  logic [DEPTH-1:0][BANK_W-1:0] entryBank;
  logic [DEPTH-1:0][ROW_W-1:0]  entryRow;
  logic [NBANK-1:0][DEPTH-1:0]  bankMask, hitMask, candMask, winMask;
  logic [NBANK-1:0]             fire;
  logic [DEPTH-1:0]             freeMask, availMask;
  logic [IDX_W-1:0]             allocIdx;
  strobes_t                     stb;

  for (genvar i = 0; i < DEPTH; i++) begin : g_decode
    assign entryBank[i] = entryAddr[i][BANK_LSB +: BANK_W];
    assign entryRow[i]  = entryAddr[i][ADDR_W-1:ROW_LSB];
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_comb begin
      for (int i = 0; i < DEPTH; i++) begin
        bankMask[b][i] = entryValid[i] && (entryBank[i] == BANK_W'(b));
        hitMask[b][i]  = bankMask[b][i] && openRowValid[b] && (entryRow[i] == openRow[b]);
      end
    end

    assign candMask[b] = (|hitMask[b]) ? hitMask[b] : bankMask[b];

    always_comb begin
      issueAddr[b] = '0;
      for (int i = 0; i < DEPTH; i++) begin
        winMask[b][i] = candMask[b][i] && !(|(candMask[b] & olderThan[i]));
        if (winMask[b][i]) issueAddr[b] = issueAddr[b] | entryAddr[i];
      end
    end

    assign issueValid[b] = |winMask[b];
    assign fire[b]       = issueValid[b] && issueReady[b];
  end

  always_comb begin
    freeMask = '0;
    for (int b = 0; b < NBANK; b++)
      if (fire[b]) freeMask = freeMask | winMask[b];
  end

  assign availMask = ~entryValid | freeMask;

  always_comb begin
    allocIdx = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (availMask[i]) allocIdx = IDX_W'(i);
  end

  assign reqReady     = |availMask;
  assign stb.allocEn  = reqValid && reqReady;
  assign stb.allocIdx = allocIdx;
  assign stb.freeMask = freeMask;
  assign strobes      = stb;
endmodule

// File: rtl/frfcfs_sched.sv
`timescale 1ns/1ps
module frfcfs_sched
  import frfcfs_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int NBANK  = 16,
  parameter int ADDR_W = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int ROW_W = ADDR_W - BANK_LSB - $clog2(NBANK)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          reqValid,
  output logic                          reqReady,
  input  logic [ADDR_W-1:0]             reqAddr,
  output logic [NBANK-1:0]              issueValid,
  input  logic [NBANK-1:0]              issueReady,
  output logic [NBANK-1:0][ADDR_W-1:0]  issueAddr,
  input  logic [NBANK-1:0]              openRowValid,
  input  logic [NBANK-1:0][ROW_W-1:0]   openRow
);
  logic [1+IDX_W+DEPTH-1:0]     strobes;
  logic [DEPTH-1:0]             entryValid;
  logic [DEPTH-1:0][ADDR_W-1:0] entryAddr;
  logic [DEPTH-1:0][DEPTH-1:0]  olderThan;

  frfcfs_ctrl #(.DEPTH(DEPTH), .NBANK(NBANK), .ADDR_W(ADDR_W)) u_ctrl (
    .reqValid(reqValid), .reqReady(reqReady),
    .issueReady(issueReady), .issueValid(issueValid), .issueAddr(issueAddr),
    .openRowValid(openRowValid), .openRow(openRow),
    .entryValid(entryValid), .entryAddr(entryAddr), .olderThan(olderThan),
    .strobes(strobes)
  );

  frfcfs_datapath #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .reqAddr(reqAddr),
    .entryValid(entryValid), .entryAddr(entryAddr), .olderThan(olderThan)
  );
endmodule

// File: rtl/frfcfs_sched_chk.sv
`timescale 1ns/1ps
module frfcfs_sched_chk
  import frfcfs_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int NBANK  = 16,
  parameter int ADDR_W = 32,
  localparam int BANK_W = $clog2(NBANK),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         reqValid,
  input logic                         reqReady,
  input logic [ADDR_W-1:0]            reqAddr,
  input logic [NBANK-1:0]             issueValid,
  input logic [NBANK-1:0]             issueReady,
  input logic [NBANK-1:0][ADDR_W-1:0] issueAddr
);
  logic [NBANK-1:0][CNT_W-1:0] pend;
  logic [NBANK-1:0]            fire;
  logic                        accept;
  int                          total;

  assign fire   = issueValid & issueReady;
  assign accept = reqValid && reqReady;

  always_comb begin
    total = 0;
    for (int b = 0; b < NBANK; b++) total = total + int'(pend[b]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pend <= '0;
    else begin
      for (int b = 0; b < NBANK; b++) begin
        if (accept && reqAddr[BANK_LSB +: BANK_W] == BANK_W'(b) && !fire[b])
          pend[b] <= pend[b] + 1'b1;
        else if (fire[b] && !(accept && reqAddr[BANK_LSB +: BANK_W] == BANK_W'(b)))
          pend[b] <= pend[b] - 1'b1;
      end
    end
  end

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (total < DEPTH || fire != '0));
  // R7
  full_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (total == DEPTH && fire == '0) |-> !reqReady);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank_chk
    // R9
    idle_low_chk: assert property (@(posedge clk) disable iff (!rstN)
      (pend[b] == '0) |-> !issueValid[b]);
    // R6
    pending_issue_chk: assert property (@(posedge clk) disable iff (!rstN)
      (pend[b] != '0) |-> issueValid[b]);
    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (issueValid[b] && !issueReady[b]) |=> issueValid[b]);
    // R2
    bank_route_chk: assert property (@(posedge clk) disable iff (!rstN)
      issueValid[b] |-> (issueAddr[b][BANK_LSB +: BANK_W] == BANK_W'(b)));
  end
endmodule

bind frfcfs_sched frfcfs_sched_chk #(.DEPTH(DEPTH), .NBANK(NBANK), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
  .issueValid(issueValid), .issueReady(issueReady), .issueAddr(issueAddr)
);

// File: tb/tb_frfcfs_sched.sv
`timescale 1ns/1ps
module tb_frfcfs_sched;
  localparam int DEPTH = 8;
  localparam int NBANK = 16;
  localparam int AW    = 32;
  localparam int RW    = 11;

  logic                      clk = 1'b0;
  logic                      rstN = 1'b0;
  logic                      reqValid = 1'b0;
  logic                      reqReady;
  logic [AW-1:0]             reqAddr = '0;
  logic [NBANK-1:0]          issueValid;
  logic [NBANK-1:0]          issueReady = '0;
  logic [NBANK-1:0][AW-1:0]  issueAddr;
  logic [NBANK-1:0]          openRowValid = '0;
  logic [NBANK-1:0][RW-1:0]  openRow = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [AW-1:0] q[$];

  always #10 clk = ~clk;

  frfcfs_sched dut (.*);

  function automatic logic [AW-1:0] mkAddr(int row, int bank, int chan, int byteOff);
    return {RW'(row), 4'(bank), 4'(chan), 13'(byteOff)};
  endfunction
  function automatic int bankOf(logic [AW-1:0] a); return int'(a[20:17]); endfunction
  function automatic int rowOf(logic [AW-1:0] a);  return int'(a[31:21]); endfunction

  function automatic int hitIdx(int b);
    foreach (q[k])
      if (bankOf(q[k]) == b && openRowValid[b] && rowOf(q[k]) == int'(openRow[b])) return k;
    return -1;
  endfunction
  function automatic int pick(int b);
    int h = hitIdx(b);
    if (h >= 0) return h;
    foreach (q[k]) if (bankOf(q[k]) == b) return k;
    return -1;
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic evalCheck();
    bit anyFire = 1'b0;
    #1;
    for (int b = 0; b < NBANK; b++) begin
      int w = pick(b);
      if (w < 0) chk(issueValid[b] == 1'b0, "R9 idle bank", 64'(issueValid[b]), 0);
      else begin
        chk(issueValid[b] == 1'b1, "R6 pending bank", 64'(issueValid[b]), 1);
        chk(issueAddr[b] == q[w], hitIdx(b) >= 0 ? "R3 open-row pick" : "R4 oldest pick",
            64'(issueAddr[b]), 64'(q[w]));
        if (issueReady[b]) anyFire = 1'b1;
      end
    end
    chk(reqReady == (q.size() < DEPTH || anyFire), "R7 ready", 64'(reqReady),
        64'(q.size() < DEPTH || anyFire));
  endtask

  task automatic advance();
    int idx[$];
    bit anyFire = 1'b0;
    for (int b = 0; b < NBANK; b++) begin
      int w = pick(b);
      if (w >= 0 && issueReady[b]) begin idx.push_back(w); anyFire = 1'b1; end
    end
    idx.rsort();
    foreach (idx[k]) q.delete(idx[k]);
    if (reqValid && (q.size() + idx.size() < DEPTH + idx.size()) && (q.size() < DEPTH || anyFire))
      q.push_back(reqAddr);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cycle(); evalCheck(); advance(); endtask

  task automatic push(logic [AW-1:0] a);
    reqValid = 1'b1; reqAddr = a; cycle(); reqValid = 1'b0;
  endtask

  task automatic drain();
    issueReady = '1; reqValid = 1'b0;
    for (int k = 0; k < DEPTH + 2; k++) cycle();
    issueReady = '0;
  endtask

  initial begin
    #4000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] aA, aB, aC, held;
    void'($urandom(32'h1234_5eed));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    chk(issueValid == '0, "R1 issueValid after reset", 64'(issueValid), 0);
    chk(reqReady == 1'b1, "R1 reqReady after reset", 64'(reqReady), 1);

    // R3 / R5 / R10 on bank 2
    aA = mkAddr(5, 2, 0, 16); aB = mkAddr(7, 2, 1, 32); aC = mkAddr(7, 2, 3, 48);
    push(aA); push(aB); push(aC);
    openRow[2] = 11'd7; openRowValid[2] = 1'b1;
    evalCheck();
    chk(issueAddr[2] == aB, "R3 hit beats older conflict", 64'(issueAddr[2]), 64'(aB));
    advance();
    openRowValid[2] = 1'b0;
    evalCheck();
    chk(issueAddr[2] == aA, "R10 no open row gives oldest", 64'(issueAddr[2]), 64'(aA));
    advance();
    openRowValid[2] = 1'b1; issueReady[2] = 1'b1;
    evalCheck();
    chk(issueAddr[2] == aB, "R5 oldest hit first", 64'(issueAddr[2]), 64'(aB));
    advance();
    evalCheck();
    chk(issueAddr[2] == aC, "R5 second hit next", 64'(issueAddr[2]), 64'(aC));
    advance();
    evalCheck();
    chk(issueAddr[2] == aA, "R4 conflict after hits drain", 64'(issueAddr[2]), 64'(aA));
    advance();
    openRowValid[2] = 1'b0;
    drain();

    // R6 two banks issue in one cycle
    push(mkAddr(1, 1, 0, 0)); push(mkAddr(2, 9, 0, 0));
    evalCheck();
    chk($countones(issueValid) == 2, "R6 parallel banks", 64'($countones(issueValid)), 2);
    advance();
    drain();

    // R2 channel bits do not alter routing
    push(mkAddr(3, 3, 15, 100));
    evalCheck();
    chk(issueValid == 16'h0008, "R2 bank field routes", 64'(issueValid), 64'h8);
    advance();
    drain();

    // R7 / R8 fill bank 0 while stalled
    for (int k = 0; k < DEPTH; k++) push(mkAddr(k, 0, 0, k));
    held = issueAddr[0];
    reqValid = 1'b1; reqAddr = mkAddr(9, 4, 0, 0);
    evalCheck();
    chk(reqReady == 1'b0, "R7 full blocks", 64'(reqReady), 0);
    advance();
    reqValid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      evalCheck();
      chk(issueValid[0] && issueAddr[0] == held, "R8 stalled issue holds",
          64'(issueAddr[0]), 64'(held));
      advance();
    end
    reqValid = 1'b1; issueReady[0] = 1'b1;
    evalCheck();
    chk(reqReady == 1'b1, "R7 ready when entry frees", 64'(reqReady), 1);
    advance();
    reqValid = 1'b0;
    drain();

    // random mix
    for (int n = 0; n < 5000; n++) begin
      reqValid = ($urandom_range(0, 9) < 7);
      reqAddr  = mkAddr($urandom_range(0, 3),
                        ($urandom_range(0, 3) == 0) ? $urandom_range(0, 15) : $urandom_range(0, 3),
                        $urandom_range(0, 15), $urandom_range(0, 8191));
      issueReady = 16'($urandom) & 16'($urandom);
      if ($urandom_range(0, 7) == 0) begin
        for (int b = 0; b < NBANK; b++) begin
          openRow[b] = RW'($urandom_range(0, 3));
          openRowValid[b] = ($urandom_range(0, 3) != 0);
        end
      end
      cycle();
    end
    reqValid = 1'b0;
    drain();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule